// File: doc/BRIEF.md
# NAND Page Hamming Code Generator

This block sits beside a NAND data port and observes every byte that the host moves through the data window, in either direction. Each accepted byte is folded into a running single-error-correcting Hamming code that covers one 256-byte chunk. The code has 6 column-parity bits, taken across the bit positions within each byte, and 16 line-parity bits, taken over each byte's parity and indexed by the byte's position in the chunk. Software reads the code after a chunk, stores it in the spare area on program, and compares it on read to locate and fix a single flipped bit.

A three-bit control register turns accumulation on, restarts it and selects whether the code is reported inverted. One control write of 3'b111 restarts and enables the generator in a single step. The code can be read as one 32-bit word or one byte at a time through a small lane selector.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, enable and invert mode are 0, the byte count and all parity bits are 0, and `code_word` reads 32'h0300_0000.
- R2: A control write stores bit 0 as enable and bit 2 as invert mode; bit 1 is a one-shot restart and is not stored. `byte_rdata` with `byte_sel`=0 returns {5'b0, mode, 1'b0, enable}.
- R3: A control write with bit 1 set zeroes the byte count and all parity bits; a data byte strobed in the same cycle as any control write is discarded.
- R4: While enable is 0, strobed bytes change neither the parity nor the byte count.
- R5: Column parity bit CP(2j+1) is the XOR of data bits whose bit index has bit j set, and CP(2j) the XOR of those with bit j clear, j=0..2, over all accepted bytes.
- R6: Line parity bit LP(2k+1) is the XOR of the parities of accepted bytes whose position (0..255, counted since the last restart) has bit k set, and LP(2k) of those with bit k clear, k=0..7.
- R7: After 256 bytes are accepted the code is frozen; further strobes leave it unchanged until the next restart.
- R8: `code_word` is {CP5..CP0, 2'b11, LP15..LP8, LP7..LP0, 8'h00}; the two lowest column-lane bits always read 1.
- R9: With invert mode 1 all 22 parity bits are reported complemented, so a chunk of 256 bytes of 8'hFF yields 32'hFFFF_FF00.
- R10: `byte_rdata` returns the LP7..LP0 lane for `byte_sel`=1, LP15..LP8 for 2 and the column lane for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_stb | input | 1 | A byte crosses the data window this cycle |
| data_byte | input | 8 | The byte crossing the data window |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 3 | Control value: bit 0 enable, bit 1 restart, bit 2 invert |
| byte_sel | input | 2 | Lane selector for the byte readback |
| byte_rdata | output | 8 | Selected lane or control readback |
| code_word | output | 32 | Full code in bits 31:8, bits 7:0 zero |

## Verification
An incrementing-position chunk of varied bytes exercises every line and column bit at once, while a chunk with a single set bit at one known position isolates the address decode and lane packing against a hand-derived word. An erased chunk of 8'hFF in invert mode separates correct inversion from raw output, and a sparse pseudo-random stream with gaps, a disable window and a control write coinciding with a data strobe tell apart the gating paths. Bytes past the 256th show whether the freeze holds.

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_stb,
  input  logic [7:0]  data_byte,
  input  logic        ctl_wr,
  input  logic [2:0]  ctl_wdata,
  input  logic [1:0]  byte_sel,
  output logic [7:0]  byte_rdata,
  output logic [31:0] code_word
);
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = ADDR_W + 1;
  localparam int LP_W   = 2 * ADDR_W;
  localparam int CP_W   = 2 * $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] col_mask(input int j);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = ((b >> j) & 1) != 0;
    return m;
  endfunction

  logic              en_q, mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LP_W-1:0]   lp_q, lp_hit, lp_o;
  logic [CP_W-1:0]   cp_q, cp_hit, cp_o;
  logic [7:0]        col_lane;

  wire full = cnt_q[ADDR_W];
  wire take = data_stb && en_q && !full && !ctl_wr;
  wire bpar = ^data_byte;

  genvar g;
  generate
    for (g = 0; g < CP_W / 2; g++) begin : g_col
      assign cp_hit[2*g+1] = ^(data_byte &  col_mask(g));
      assign cp_hit[2*g]   = ^(data_byte & ~col_mask(g));
    end
    for (g = 0; g < ADDR_W; g++) begin : g_line
      assign lp_hit[2*g+1] = bpar &  cnt_q[g];
      assign lp_hit[2*g]   = bpar & ~cnt_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
      lp_q   <= '0;
      cp_q   <= '0;
    end else if (ctl_wr) begin
      en_q   <= ctl_wdata[0];
      mode_q <= ctl_wdata[2];
      if (ctl_wdata[1]) begin
        cnt_q <= '0;
        lp_q  <= '0;
        cp_q  <= '0;
      end
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      lp_q  <= lp_q ^ lp_hit;
      cp_q  <= cp_q ^ cp_hit;
    end
  end

  assign lp_o      = mode_q ? ~lp_q : lp_q;
  assign cp_o      = mode_q ? ~cp_q : cp_q;
  assign col_lane  = {cp_o, 2'b11};
  assign code_word = {col_lane, lp_o[15:8], lp_o[7:0], 8'h00};

  always_comb begin
    case (byte_sel)
      2'd0:    byte_rdata = {5'b0, mode_q, 1'b0, en_q};
      2'd1:    byte_rdata = lp_o[7:0];
      2'd2:    byte_rdata = lp_o[15:8];
      default: byte_rdata = col_lane;
    endcase
  end

  // R2
  ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (en_q == $past(ctl_wdata[0])) && (mode_q == $past(ctl_wdata[2])));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1]) |=> (cnt_q == '0) && (lp_q == '0) && (cp_q == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctl_wr) |=> $stable(cnt_q) && $stable(lp_q) && $stable(cp_q));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && en_q && !cnt_q[ADDR_W] && !ctl_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[ADDR_W] && !ctl_wr) |=> $stable(lp_q) && $stable(cp_q) && $stable(cnt_q));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(1 << ADDR_W));
endmodule

// File: tb/test_nand_hamming_ecc.sv
module test_nand_hamming_ecc;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic data_stb = 1'b0, ctl_wr = 1'b0;
  logic [7:0] data_byte = '0;
  logic [2:0] ctl_wdata = '0;
  logic [1:0] byte_sel = '0;
  wire  [7:0] byte_rdata;
  wire  [31:0] code_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_hamming_ecc i_nand_hamming_ecc (
    .clk(clk), .rst_n(rst_n), .data_stb(data_stb), .data_byte(data_byte),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .byte_sel(byte_sel),
    .byte_rdata(byte_rdata), .code_word(code_word));

  int vectors = 0, fails = 0;
  string req = "R1";
  bit chk_on = 0;

  bit m_en, m_mode;
  int m_cnt;
  logic [7:0] m_buf [0:255];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_cnt = 0;
    end else if (ctl_wr) begin
      m_en = ctl_wdata[0]; m_mode = ctl_wdata[2];
      if (ctl_wdata[1]) m_cnt = 0;
    end else if (data_stb && m_en && m_cnt < 256) begin
      m_buf[m_cnt] = data_byte;
      m_cnt++;
    end
  end

  function automatic logic [31:0] model_word();
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < m_cnt; i++)
      for (int b = 0; b < 8; b++)
        if (m_buf[i][b]) begin
          for (int j = 0; j < 3; j++)
            if (((b >> j) & 1) != 0) cp[2*j+1] ^= 1'b1; else cp[2*j] ^= 1'b1;
          for (int k = 0; k < 8; k++)
            if (((i >> k) & 1) != 0) lp[2*k+1] ^= 1'b1; else lp[2*k] ^= 1'b1;
        end
    if (m_mode) begin lp = ~lp; cp = ~cp; end
    return {cp, 2'b11, lp, 8'h00};
  endfunction

  function automatic logic [7:0] model_byte(input logic [1:0] s);
    logic [31:0] w = model_word();
    case (s)
      2'd0: return {5'b0, m_mode, 1'b0, m_en};
      2'd1: return w[15:8];
      2'd2: return w[23:16];
      default: return w[31:24];
    endcase
  endfunction

  task automatic chk32(input string r, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    chk32({req, " word"}, code_word, model_word());
    chk32({req, " lane"}, {24'h0, byte_rdata}, {24'h0, model_byte(byte_sel)});
  end

  task automatic cyc(input logic stb, input logic [7:0] d, input logic w, input logic [2:0] wd);
    @(posedge clk); #1;
    data_stb = stb; data_byte = d; ctl_wr = w; ctl_wdata = wd;
    byte_sel = byte_sel + 2'd1;
  endtask
  task automatic idle(); cyc(1'b0, 8'h00, 1'b0, 3'b000); endtask
  task automatic put(input logic [7:0] d); cyc(1'b1, d, 1'b0, 3'b000); endtask
  task automatic ctl(input logic [2:0] v); cyc(1'b0, 8'h00, 1'b1, v); endtask
  task automatic lane(input logic [1:0] s, input logic [7:0] exp, input string r);
    @(posedge clk); #1; byte_sel = s; data_stb = 0; ctl_wr = 0;
    @(negedge clk);
    chk32(r, {24'h0, byte_rdata}, {24'h0, exp});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    logic [7:0]  lf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    chk32("R1 reset word", code_word, 32'h0300_0000);
    chk_on = 1;
    idle(); idle();

    req = "R2";
    ctl(3'b101); idle(); idle(); idle(); idle();
    ctl(3'b011); idle(); idle(); idle();

    req = "R4";
    put(8'h3C); put(8'h81); put(8'h07);
    ctl(3'b000);
    for (int i = 0; i < 6; i++) put(8'(i * 29 + 5));
    ctl(3'b001);
    put(8'hE2); put(8'h19); idle();

    req = "R3";
    cyc(1'b1, 8'hA5, 1'b1, 3'b111);
    idle();
    @(negedge clk);
    chk32("R3 restart with invert", code_word, 32'hFFFF_FF00);

    req = "R5/R6/R8/R10";
    for (int i = 0; i < 256; i++) put(8'((i * 37 + 11) ^ (i >> 3)));
    idle(); idle();

    req = "R7";
    @(negedge clk); held = code_word;
    for (int i = 0; i < 20; i++) put(8'(i + 1));
    idle();
    @(negedge clk);
    chk32("R7 frozen after chunk", code_word, held);

    req = "R9";
    ctl(3'b111);
    for (int i = 0; i < 256; i++) put(8'hFF);
    idle();
    @(negedge clk);
    chk32("R9 erased chunk", code_word, 32'hFFFF_FF00);

    req = "R8";
    ctl(3'b011);
    for (int i = 0; i < 256; i++) put(i == 8'h5A ? 8'h08 : 8'h00);
    idle();
    @(negedge clk);
    chk32("R8 single bit packing", code_word, 32'h6B66_9900);
    lane(2'd1, 8'h99, "R10 lane 1");
    lane(2'd2, 8'h66, "R10 lane 2");
    lane(2'd3, 8'h6B, "R10 lane 3");
    lane(2'd0, 8'h01, "R2 control readback");

    req = "R4/R6";
    ctl(3'b111);
    lf = 8'h1D;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (i == 150) ctl(3'b100);
      else if (i == 170) ctl(3'b101);
      else cyc(lf[0] | lf[6], lf ^ 8'(i), 1'b0, 3'b000);
    end
    idle(); idle();
    chk_on = 0;
    finish_run();
  end
endmodule